// File: doc/BRIEF.md
# Shared Enable / External Clock Selector

This block serves a switching controller whose single digital control input has two jobs. Held steadily low, the input parks the controller in standby. Held steadily high, it enables switching paced by an internal free-running oscillator. Driven with a square wave, it asks the controller to lock its switching cycles to that wave. The block samples the input on a fast system clock through a synchroniser. It tells a steady level from a toggling one by watching how long it has been since the last rising edge. It emits one `cycle_start` pulse per switching period, taken either from the internal oscillator or from the input's rising edges.

The move to external pacing is held off by a settling window. During that window the internal oscillator keeps pacing the cycles. External pacing is granted only if the edges keep arriving for the whole window. When the edges stop for longer than one period at the slowest accepted external frequency, the block falls back on the level the input has settled at. All durations are counted in system-clock cycles and are derived from the system clock frequency and a variant parameter. The fast variant runs its oscillator at 450 kHz and accepts 440 to 600 kHz. The slow variant runs at 300 kHz and accepts 280 to 500 kHz.

Top module: `ensync_clock_select`

## Requirements
- R1: During and right after reset `standby` is 1, `sync_active` is 0 and `cycle_start` is 0; `standby` and `sync_active` are never 1 together.
- R2: While the input is steadily low, `standby` is 1 and no `cycle_start` pulse is issued.
- R3: While the input is steadily high, `standby` is 0 and `sync_active` is 0. `cycle_start` is a one-cycle pulse repeating every OSC_CYCLES = SYS_CLK_KHZ/450 system cycles (the fast variant, which is the default) or SYS_CLK_KHZ/300 (the slow variant).
- R4: In external mode (`sync_active` = 1), each rising edge of the input produces exactly one `cycle_start` pulse, so the pulse spacing equals the input period.
- R5: `sync_active` rises only after the input has kept toggling for SETTLE_CYCLES = SYS_CLK_KHZ*SETTLE_US/1000 system cycles (25 µs by default) in internal-oscillator mode. It never rises straight out of standby.
- R6: Falling edges of the input start no cycle. In external mode every `cycle_start` pulse is seen while the input is still high, for any duty cycle in the accepted range.
- R7: If no rising edge arrives for TIMEOUT_CYCLES, set at 1.5 times the period of the slowest accepted external frequency, external mode ends. The block then runs the internal oscillator if the input is high, or goes to standby if it is low.
- R8: Square waves at both ends of the accepted range are locked to: for the fast variant, 440 kHz at 25% duty and 600 kHz at 75% duty.
- R9: A toggling burst that ends before the settling window completes never sets `sync_active`. If the input then stays high, internal-oscillator pacing continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_sync_in | input | 1 | Shared enable / external clock input, asynchronous |
| standby | output | 1 | 1 while the controller is parked |
| sync_active | output | 1 | 1 while cycles follow the external clock |
| cycle_start | output | 1 | One-cycle pulse starting each switching period |

## Verification
A wrong mode state shows at the ports within a few cycles. `standby` or `sync_active` takes the wrong value, or the `cycle_start` spacing switches between the oscillator period and the input period at the wrong moment. A settle counter that is off shows as `sync_active` rising too early or too late against a window of a few hundred cycles around the settling time. A broken idle timer shows either as no fallback a thousand cycles after the edges stop, or as a false fallback while edges are still arriving. Checks on the pulse count over whole input periods and on the input level at each pulse catch edge polarity and double-trigger faults.

// File: rtl/ensync_pkg.sv
package ensync_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY  = 2'd0,
    MODE_INTERNAL = 2'd1,
    MODE_ARMING   = 2'd2,
    MODE_EXTERNAL = 2'd3
  } ensync_mode_e;
endpackage

// File: rtl/ensync_input_sync.sv
module ensync_input_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              level_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~level_d;
endmodule

// File: rtl/ensync_edge_watch.sv
module ensync_edge_watch #(
  parameter int TIMEOUT_CYCLES = 426
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  output logic quiet
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst)                    idle_cnt <= LIMIT;
    else if (rise)              idle_cnt <= '0;
    else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
  end

  assign quiet = (idle_cnt == LIMIT);
endmodule

// File: rtl/ensync_osc.sv
module ensync_osc #(
  parameter int PERIOD = 277
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run)    phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  assign tick = run && (phase == '0);
endmodule

// File: rtl/ensync_mode_ctrl.sv
module ensync_mode_ctrl
  import ensync_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3125
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         level,
  input  logic         rise,
  input  logic         quiet,
  input  logic         osc_tick,
  output ensync_mode_e mode_next,
  output logic         standby,
  output logic         sync_active,
  output logic         cycle_start
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);

  ensync_mode_e  mode_q;
  logic [SW-1:0] settle_cnt;
  logic          idle;

  assign idle = quiet && !rise;

  always_comb begin
    mode_next = mode_q;
    unique case (mode_q)
      MODE_STANDBY: begin
        if (rise) mode_next = MODE_INTERNAL;
      end
      MODE_INTERNAL: begin
        if (rise)                 mode_next = MODE_ARMING;
        else if (idle && !level)  mode_next = MODE_STANDBY;
      end
      MODE_ARMING: begin
        if (idle)                            mode_next = level ? MODE_INTERNAL : MODE_STANDBY;
        else if (settle_cnt == SETTLE_LAST)  mode_next = MODE_EXTERNAL;
      end
      MODE_EXTERNAL: begin
        if (idle) mode_next = level ? MODE_INTERNAL : MODE_STANDBY;
      end
      default: mode_next = MODE_STANDBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_STANDBY;
      settle_cnt  <= '0;
      standby     <= 1'b1;
      sync_active <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      mode_q      <= mode_next;
      if (mode_q != MODE_ARMING)           settle_cnt <= '0;
      else if (settle_cnt != SETTLE_LAST)  settle_cnt <= settle_cnt + 1'b1;
      standby     <= (mode_next == MODE_STANDBY);
      sync_active <= (mode_next == MODE_EXTERNAL);
      cycle_start <= ((mode_next == MODE_EXTERNAL) && rise) || osc_tick;
    end
  end
endmodule

// File: rtl/ensync_clock_select.sv
module ensync_clock_select
  import ensync_pkg::*;
#(
  parameter int SYS_CLK_KHZ  = 125000,
  parameter bit FAST_VARIANT = 1'b1,
  parameter int SETTLE_US    = 25,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_sync_in,
  output logic standby,
  output logic sync_active,
  output logic cycle_start
);
  localparam int OSC_KHZ        = FAST_VARIANT ? 450 : 300;
  localparam int MIN_EXT_KHZ    = FAST_VARIANT ? 440 : 280;
  localparam int OSC_CYCLES     = SYS_CLK_KHZ / OSC_KHZ;
  localparam int TIMEOUT_CYCLES = (SYS_CLK_KHZ / MIN_EXT_KHZ) * 3 / 2;
  localparam int SETTLE_CYCLES  = SYS_CLK_KHZ * SETTLE_US / 1000;

  logic         level;
  logic         rise;
  logic         quiet;
  logic         osc_tick;
  logic         osc_run;
  ensync_mode_e mode_next;

  ensync_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin   (en_sync_in),
    .level (level),
    .rise  (rise)
  );

  ensync_edge_watch #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_watch (
    .clk   (clk),
    .rst   (rst),
    .rise  (rise),
    .quiet (quiet)
  );

  assign osc_run = (mode_next == MODE_INTERNAL) || (mode_next == MODE_ARMING);

  ensync_osc #(.PERIOD(OSC_CYCLES)) u_osc (
    .clk  (clk),
    .rst  (rst),
    .run  (osc_run),
    .tick (osc_tick)
  );

  ensync_mode_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .level       (level),
    .rise        (rise),
    .quiet       (quiet),
    .osc_tick    (osc_tick),
    .mode_next   (mode_next),
    .standby     (standby),
    .sync_active (sync_active),
    .cycle_start (cycle_start)
  );
endmodule

// File: rtl/ensync_clock_select_chk.sv
module ensync_clock_select_chk #(
  parameter int SYS_CLK_KHZ  = 125000,
  parameter bit FAST_VARIANT = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic standby,
  input logic sync_active,
  input logic cycle_start
);
  localparam int OSC_CYCLES = SYS_CLK_KHZ / (FAST_VARIANT ? 450 : 300);
  localparam int GW = $clog2(OSC_CYCLES + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(OSC_CYCLES);

  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst)                   gap_cnt <= GAP_MAX;
    else if (cycle_start)      gap_cnt <= '0;
    else if (gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(standby && sync_active)); // R1

  AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (rst)
    standby |-> !cycle_start); // R2

  AST_OSC_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && !sync_active && !$past(sync_active) && !$past(standby))
      |-> (gap_cnt >= GW'(OSC_CYCLES - 1))); // R3

  AST_SYNC_VIA_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_active) |-> !$past(standby)); // R5
endmodule

bind ensync_clock_select ensync_clock_select_chk #(
  .SYS_CLK_KHZ  (SYS_CLK_KHZ),
  .FAST_VARIANT (FAST_VARIANT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .standby     (standby),
  .sync_active (sync_active),
  .cycle_start (cycle_start)
);

// File: tb/ensync_clock_select_test.sv
module ensync_clock_select_test;
  localparam int SYS_KHZ = 125000;
  localparam int OSC_EXP = SYS_KHZ / 450;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_sync_in = 1'b0;
  logic standby, sync_active, cycle_start;

  int checks = 0;
  int fails  = 0;

  bit sq_on     = 1'b0;
  bit dc_level  = 1'b0;
  int sq_period = 250;
  int sq_high   = 125;

  int cyc       = 0;
  int pulse_cnt = 0;
  int last_t    = -1;
  int last_iv   = 0;
  int low_pulse = 0;
  int sync_seen = 0;

  always #4 clk = ~clk;

  ensync_clock_select uut (
    .clk         (clk),
    .rst         (rst),
    .en_sync_in  (en_sync_in),
    .standby     (standby),
    .sync_active (sync_active),
    .cycle_start (cycle_start)
  );

  // input pattern generator
  always begin
    if (sq_on) begin
      en_sync_in = 1'b1;
      repeat (sq_high) @(negedge clk);
      en_sync_in = 1'b0;
      repeat (sq_period - sq_high) @(negedge clk);
    end else begin
      en_sync_in = dc_level;
      @(negedge clk);
    end
  end

  // output monitor, sampled between rising edges
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst && cycle_start) begin
      pulse_cnt = pulse_cnt + 1;
      if (last_t >= 0) last_iv = cyc - last_t;
      last_t = cyc;
      if (sync_active && !en_sync_in) low_pulse = low_pulse + 1;
    end
    if (!rst && sync_active) sync_seen = sync_seen + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_iv(output int iv);
    int c0 = pulse_cnt;
    wait (pulse_cnt >= c0 + 2);
    @(negedge clk);
    iv = last_iv;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    dc_level = 1'b0;
    wait_cycles(5);
    check(standby == 1'b1, "R1 standby in reset", standby, 1);
    rst = 1'b0;
    wait_cycles(2);
    check(standby == 1'b1, "R1 standby after reset", standby, 1);
    check(sync_active == 1'b0, "R1 sync_active after reset", sync_active, 0);
    check(cycle_start == 1'b0, "R1 cycle_start after reset", cycle_start, 0);
  endtask

  task automatic t_standby_low();
    int c0;
    dc_level = 1'b0;
    c0 = pulse_cnt;
    wait_cycles(2000);
    check(pulse_cnt == c0, "R2 no pulses while low", pulse_cnt - c0, 0);
    check(standby == 1'b1, "R2 standby while low", standby, 1);
  endtask

  task automatic t_dc_high();
    int iv;
    dc_level = 1'b1;
    wait_cycles(50);
    check(standby == 1'b0, "R3 run on steady high", standby, 0);
    measure_iv(iv);
    check(iv == OSC_EXP, "R3 internal period", iv, OSC_EXP);
    check(sync_active == 1'b0, "R3 no sync on steady high", sync_active, 0);
  endtask

  task automatic t_external(input int period, input int high, input string req);
    int iv;
    int c0;
    sq_period = period;
    sq_high   = high;
    sq_on     = 1'b1;
    wait_cycles(3000);
    check(sync_active == 1'b0, "R5 no sync before settle", sync_active, 0);
    wait_cycles(700);
    check(sync_active == 1'b1, {req, " R5 sync after settle"}, sync_active, 1);
    check(standby == 1'b0, {req, " R1 not standby in sync"}, standby, 0);
    measure_iv(iv);
    check(iv == period, {req, " R4 pulse spacing equals input period"}, iv, period);
    low_pulse = 0;
    c0 = pulse_cnt;
    wait_cycles(10 * period);
    check(pulse_cnt - c0 == 10, {req, " R6 one pulse per period"}, pulse_cnt - c0, 10);
    check(low_pulse == 0, {req, " R6 no pulse on falling edge"}, low_pulse, 0);
  endtask

  task automatic t_stop_high();
    int iv;
    dc_level = 1'b1;
    sq_on = 1'b0;
    wait_cycles(1200);
    check(sync_active == 1'b0, "R7 fallback leaves sync", sync_active, 0);
    check(standby == 1'b0, "R7 fallback high runs", standby, 0);
    measure_iv(iv);
    check(iv == OSC_EXP, "R7 internal period after fallback", iv, OSC_EXP);
  endtask

  task automatic t_stop_low();
    int c0;
    dc_level = 1'b0;
    sq_on = 1'b0;
    wait_cycles(1200);
    check(standby == 1'b1, "R7 fallback low parks", standby, 1);
    check(sync_active == 1'b0, "R7 fallback low leaves sync", sync_active, 0);
    c0 = pulse_cnt;
    wait_cycles(1000);
    check(pulse_cnt == c0, "R2 silent after fallback low", pulse_cnt - c0, 0);
  endtask

  task automatic t_abort_burst();
    int iv;
    sync_seen = 0;
    sq_period = 250;
    sq_high   = 125;
    dc_level  = 1'b1;
    sq_on     = 1'b1;
    wait_cycles(1500);
    sq_on = 1'b0;
    wait_cycles(2500);
    check(sync_seen == 0, "R9 short burst never syncs", sync_seen, 0);
    check(standby == 1'b0, "R9 still running", standby, 0);
    measure_iv(iv);
    check(iv == OSC_EXP, "R9 internal period kept", iv, OSC_EXP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails  = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_standby_low();
    t_dc_high();
    t_external(250, 125, "500kHz from internal");
    t_stop_high();
    dc_level = 1'b0;
    wait_cycles(200);
    check(standby == 1'b1, "R2 steady low parks", standby, 1);
    t_external(284, 71, "R8 440kHz 25pct");
    t_stop_low();
    t_external(208, 156, "R8 600kHz 75pct");
    t_stop_high();
    t_abort_burst();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule